// File: doc/BRIEF.md
# Dual Simultaneous-Sampling ADC Controller

This block is the host side of a dual 12-bit successive-approximation converter that has a parallel output bus. It starts each conversion with an active-low convert pulse and selects one of two input pairs with a single select line. It then waits for the converter's busy flag to fall. After that it reads the two channel results with paired chip-select and read strobes. Each result is handed on as a one-cycle valid pulse. The pulse carries the 12-bit data, a channel tag and the pair that was selected for that conversion.

It can run one conversion per start request, or run without stopping while the run input is high. In run mode a new conversion is launched on the same edge that sees busy fall. The two reads of the finished result then take place while the next conversion is in progress, so the interface does not sit idle waiting for the reads. A cycle counter guards each conversion. If busy never falls, the block reports an error and returns to idle.

Top module: `dadc_ctrl`

## Requirements
- R1: While reset is asserted, convst_n_o, cs_n_o and rd_n_o are high, and res_valid_o and timeout_o are low.
- R2: Each convert pulse holds convst_n_o low for exactly LOW_CYC cycles. LOW_CYC is MIN_CONVST_PS divided by CLK_PERIOD_PS, rounded up, with a minimum of 1. With the defaults this is 2 cycles.
- R3: In idle, a high start_i or run_i at a clock edge starts a conversion. The next cycle is a setup cycle with convst_n_o still high, and convst_n_o goes low in the cycle after that. A start_i pulse while a conversion is in progress has no effect.
- R4: pair_sel_o takes the value of pair_req_i sampled at the starting edge (0 selects input pair 0, 1 selects input pair 1). It stays unchanged through the convert pulse and until busy falls.
- R5: After the convert pulse, a clock edge that samples busy_i low, following a sample of busy_i high, marks the result as ready. The first read access begins in the next cycle.
- R6: During each access, cs_n_o and rd_n_o go low together for RD_HOLD cycles (default 1). Between the two accesses of a result they return high for at least one cycle, and they stay high when no read is in progress.
- R7: Each finished conversion gives two one-cycle res_valid_o pulses. The first has res_chan_o=0 (channel A) and carries the data from the first access. The second has res_chan_o=1 (channel B) and carries the data from the second access. The data is sampled on the edge that ends the strobe-low period. The ready edge is E. The A pulse is visible after edge E+2, and the B pulse after edge E+4.
- R8: res_pair_o of both results equals the pair_sel_o value that was in force during that conversion, even if a later conversion has changed the select line since.
- R9: With run_i high, the edge that detects busy falling also starts the setup cycle of the next conversion. convst_n_o goes low one cycle later, and the reads of the previous result overlap the new conversion.
- R10: If busy has not fallen within TIMEOUT_CYC cycles after the convert pulse ends, timeout_o pulses high for one cycle and the block returns to idle with no read. The error is visible after edge T+3+TIMEOUT_CYC, where T is the starting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one conversion |
| run_i | input | 1 | Keep converting back to back while high |
| pair_req_i | input | 1 | Requested input pair for the next conversion |
| busy_i | input | 1 | Converter busy flag |
| data_i | input | 12 | Converter parallel data bus |
| convst_n_o | output | 1 | Active-low convert-start pulse |
| pair_sel_o | output | 1 | Input pair select line to the converter |
| cs_n_o | output | 1 | Active-low chip select |
| rd_n_o | output | 1 | Active-low read strobe |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | 12 | Result data |
| res_chan_o | output | 1 | Channel tag, 0 = A, 1 = B |
| res_pair_o | output | 1 | Pair that was converted for this result |
| timeout_o | output | 1 | One-cycle busy timeout error |

## Verification
The bench counts from the negative edge on which its converter model drops busy. The ready edge is the next rising edge, so the A result must be seen exactly three negative edges after the drop and the B result five after it. Each expected result is queued together with its due cycle and compared in that cycle. A convert pulse follows its starting edge by two cycles, and after a busy drop in run mode the next pulse is also two cycles later. The bench checks the select line in the cycle between. The timeout test counts negative edges from the start request and expects the error 68 edges later with the default parameters, with no strobe or result afterwards.

// File: rtl/dadc_pkg.sv
package dadc_pkg;

  typedef enum logic [1:0] {
    CV_IDLE  = 2'd0,
    CV_SETUP = 2'd1,
    CV_PULSE = 2'd2,
    CV_WAIT  = 2'd3
  } cv_state_t;

  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,
    RS_LOW_A = 2'd1,
    RS_GAP   = 2'd2,
    RS_LOW_B = 2'd3
  } rs_state_t;

  // Cycles needed so that a low pulse spans at least min_ps.
  function automatic int low_cycles(int clk_ps, int min_ps);
    int n;
    n = (min_ps + clk_ps - 1) / clk_ps;
    if (n < 1) n = 1;
    return n;
  endfunction

  // Counter width able to hold 0 .. n-1.
  function automatic int cnt_w(int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/dadc_conv_seq.sv
module dadc_conv_seq
  import dadc_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 10000,
  parameter int MIN_LOW_PS    = 15000,
  parameter int TIMEOUT_CYC   = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic run_i,
  input  logic pair_req_i,
  input  logic busy_i,
  output logic convst_n_o,
  output logic pair_sel_o,
  output logic done_o,
  output logic done_pair_o,
  output logic timeout_o
);

  localparam int LOW_CYC = low_cycles(CLK_PERIOD_PS, MIN_LOW_PS);
  localparam int LCW     = cnt_w(LOW_CYC);
  localparam int TCW     = cnt_w(TIMEOUT_CYC);
  localparam int RUNW    = cnt_w(LOW_CYC + 2) + 1;

  cv_state_t      st;
  logic [LCW-1:0] lcnt;
  logic [TCW-1:0] tcnt;
  logic           pair_q;
  logic           busy_q;
  logic           done_q;
  logic           done_pair_q;
  logic           tmo_q;

  // named events
  logic trig;
  logic busy_fall;
  logic pulse_last;
  logic wait_expired;

  assign trig         = start_i | run_i;
  assign busy_fall    = busy_q & ~busy_i;
  assign pulse_last   = (lcnt == LCW'(LOW_CYC - 1));
  assign wait_expired = (tcnt == TCW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= CV_IDLE;
      lcnt        <= '0;
      tcnt        <= '0;
      pair_q      <= 1'b0;
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      done_pair_q <= 1'b0;
      tmo_q       <= 1'b0;
    end else begin
      busy_q <= busy_i;
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      case (st)
        CV_IDLE: begin
          if (trig) begin
            st     <= CV_SETUP;
            pair_q <= pair_req_i;
          end
        end
        CV_SETUP: begin
          st   <= CV_PULSE;
          lcnt <= '0;
        end
        CV_PULSE: begin
          if (pulse_last) begin
            st   <= CV_WAIT;
            tcnt <= '0;
          end else begin
            lcnt <= lcnt + 1'b1;
          end
        end
        CV_WAIT: begin
          if (busy_fall) begin
            done_q      <= 1'b1;
            done_pair_q <= pair_q;
            if (run_i) begin
              st     <= CV_SETUP;
              pair_q <= pair_req_i;
            end else begin
              st <= CV_IDLE;
            end
          end else if (wait_expired) begin
            tmo_q <= 1'b1;
            st    <= CV_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: st <= CV_IDLE;
      endcase
    end
  end

  assign convst_n_o  = (st != CV_PULSE);
  assign pair_sel_o  = pair_q;
  assign done_o      = done_q;
  assign done_pair_o = done_pair_q;
  assign timeout_o   = tmo_q;

  // checker state: length of the current low phase
  logic [RUNW-1:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           low_run <= '0;
    else if (!convst_n_o) low_run <= low_run + 1'b1;
    else                  low_run <= '0;
  end

  a_r2_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(convst_n_o) |-> (low_run == RUNW'(LOW_CYC)));

  a_r4_pair_hold_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!convst_n_o && !$past(convst_n_o)) |-> $stable(pair_sel_o));

  a_r4_pair_hold_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CV_WAIT && $past(st) == CV_WAIT) |-> $stable(pair_sel_o));

  a_r5_done_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!$past(busy_i) && $past(busy_i, 2)));

  a_r10_timeout_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (convst_n_o && !done_o));

  a_r10_timeout_single: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);

endmodule

// File: rtl/dadc_read_seq.sv
module dadc_read_seq
  import dadc_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int RD_HOLD = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic              pair_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              cs_n_o,
  output logic              rd_n_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              chan_o,
  output logic              pair_o
);

  localparam int HCW  = cnt_w(RD_HOLD);
  localparam int RUNW = cnt_w(RD_HOLD + 2) + 1;

  rs_state_t         st;
  logic [HCW-1:0]    hcnt;
  logic              pair_q;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic              chan_q;

  // named events
  logic strobe_low;
  logic hold_last;

  assign strobe_low = (st == RS_LOW_A) || (st == RS_LOW_B);
  assign hold_last  = (hcnt == HCW'(RD_HOLD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= RS_IDLE;
      hcnt    <= '0;
      pair_q  <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
      chan_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      case (st)
        RS_IDLE: begin
          if (done_i) begin
            st     <= RS_LOW_A;
            hcnt   <= '0;
            pair_q <= pair_i;
          end
        end
        RS_LOW_A: begin
          if (hold_last) begin
            valid_q <= 1'b1;
            data_q  <= data_i;
            chan_q  <= 1'b0;
            st      <= RS_GAP;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        RS_GAP: begin
          st   <= RS_LOW_B;
          hcnt <= '0;
        end
        RS_LOW_B: begin
          if (hold_last) begin
            valid_q <= 1'b1;
            data_q  <= data_i;
            chan_q  <= 1'b1;
            st      <= RS_IDLE;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        default: st <= RS_IDLE;
      endcase
    end
  end

  assign cs_n_o  = ~strobe_low;
  assign rd_n_o  = ~strobe_low;
  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign chan_o  = chan_q;
  assign pair_o  = pair_q;

  // checker state
  logic            last_chan_q;
  logic [RUNW-1:0] rd_low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_chan_q <= 1'b1;
      rd_low_run  <= '0;
    end else begin
      if (valid_o) last_chan_q <= chan_o;
      if (!rd_n_o) rd_low_run <= rd_low_run + 1'b1;
      else         rd_low_run <= '0;
    end
  end

  a_r6_strobe_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n_o) |-> (rd_low_run == RUNW'(RD_HOLD)));

  a_r7_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (rd_n_o && !$past(rd_n_o)));

  a_r7_chan_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (chan_o != last_chan_q));

  a_r9_read_done_before_next: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |-> (st == RS_IDLE));

endmodule

// File: rtl/dadc_ctrl.sv
module dadc_ctrl #(
  parameter int DATA_W        = 12,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int MIN_CONVST_PS = 15000,
  parameter int TIMEOUT_CYC   = 64,
  parameter int RD_HOLD       = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              run_i,
  input  logic              pair_req_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              convst_n_o,
  output logic              pair_sel_o,
  output logic              cs_n_o,
  output logic              rd_n_o,
  output logic              res_valid_o,
  output logic [DATA_W-1:0] res_data_o,
  output logic              res_chan_o,
  output logic              res_pair_o,
  output logic              timeout_o
);

  logic conv_done;
  logic conv_done_pair;

  dadc_conv_seq #(
    .CLK_PERIOD_PS (CLK_PERIOD_PS),
    .MIN_LOW_PS    (MIN_CONVST_PS),
    .TIMEOUT_CYC   (TIMEOUT_CYC)
  ) u_conv (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .run_i       (run_i),
    .pair_req_i  (pair_req_i),
    .busy_i      (busy_i),
    .convst_n_o  (convst_n_o),
    .pair_sel_o  (pair_sel_o),
    .done_o      (conv_done),
    .done_pair_o (conv_done_pair),
    .timeout_o   (timeout_o)
  );

  dadc_read_seq #(
    .DATA_W  (DATA_W),
    .RD_HOLD (RD_HOLD)
  ) u_read (
    .clk     (clk),
    .rst_n   (rst_n),
    .done_i  (conv_done),
    .pair_i  (conv_done_pair),
    .data_i  (data_i),
    .cs_n_o  (cs_n_o),
    .rd_n_o  (rd_n_o),
    .valid_o (res_valid_o),
    .data_o  (res_data_o),
    .chan_o  (res_chan_o),
    .pair_o  (res_pair_o)
  );

  a_r8_tag_from_done: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_chan_o) |-> (res_pair_o == $past(conv_done_pair, 2)));

endmodule

// File: tb/dadc_ctrl_tb_top.sv
module dadc_ctrl_tb_top;

  localparam int TO = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, run = 1'b0, preq = 1'b0, busy = 1'b0;
  logic [11:0] dbus = '0;
  logic convst_n, pair_sel, cs_n, rd_n, res_valid, res_chan, res_pair, tmo;
  logic [11:0] res_data;

  dadc_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .run_i(run), .pair_req_i(preq),
    .busy_i(busy), .data_i(dbus), .convst_n_o(convst_n), .pair_sel_o(pair_sel),
    .cs_n_o(cs_n), .rd_n_o(rd_n), .res_valid_o(res_valid), .res_data_o(res_data),
    .res_chan_o(res_chan), .res_pair_o(res_pair), .timeout_o(tmo)
  );

  initial forever #5 clk = ~clk;

  int cyc = 0;
  initial forever begin @(posedge clk); cyc++; end

  int checks = 0, fails = 0;
  bit model_en = 1'b1;
  int conv_cnt = 0, falls_cnt = 0;
  logic [11:0] latA = '0, latB = '0;
  bit rd_tog = 1'b0;
  bit finished = 1'b0;
  logic [11:0] q_data[$];
  bit q_chan[$];
  bit q_pair[$];
  int q_cyc[$];

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_low(int clk_ps, int min_ps);
    int n = min_ps / clk_ps;
    if (n * clk_ps < min_ps) n++;
    if (n == 0) n = 1;
    return n;
  endfunction

  // converter model: busy, result latch, expected queue
  initial begin : conv_model
    bit p;
    int n;
    forever begin
      @(negedge clk);
      if (rst_n && model_en && !convst_n) begin
        p = pair_sel;
        conv_cnt++;
        busy = 1'b1;
        n = 6 + int'($urandom % 15);
        repeat (n) begin
          @(negedge clk);
          chk(pair_sel == p, "R4 select held", pair_sel, p);
        end
        latA = 12'($urandom);
        latB = 12'($urandom);
        rd_tog = 1'b0;
        q_data.push_back(latA); q_chan.push_back(1'b0); q_pair.push_back(p); q_cyc.push_back(cyc + 3);
        q_data.push_back(latB); q_chan.push_back(1'b1); q_pair.push_back(p); q_cyc.push_back(cyc + 5);
        busy = 1'b0;
        falls_cnt++;
      end
    end
  end

  // bus model and result monitor
  initial begin : mon
    int lowc;
    int lowr;
    bit prev_acc;
    logic [11:0] d;
    bit c, p;
    int cy;
    lowc = 0; lowr = 0; prev_acc = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (!cs_n && !rd_n) begin
          if (!prev_acc) begin
            dbus = rd_tog ? latB : latA;
            rd_tog = 1'b1;
          end
          prev_acc = 1'b1;
          lowr++;
        end else begin
          prev_acc = 1'b0;
          if (lowr != 0) begin
            chk(lowr == 1, "R6 strobe width", lowr, 1);
            lowr = 0;
          end
        end
        chk(cs_n == rd_n, "R6 strobes paired", cs_n, rd_n);
        if (!convst_n) lowc++;
        else if (lowc != 0) begin
          chk(lowc == exp_low(10000, 15000), "R2 pulse width", lowc, exp_low(10000, 15000));
          lowc = 0;
        end
        if (res_valid) begin
          if (q_data.size() == 0) chk(1'b0, "R7 unexpected result", res_data, 0);
          else begin
            d = q_data.pop_front(); c = q_chan.pop_front();
            p = q_pair.pop_front(); cy = q_cyc.pop_front();
            chk(res_data == d, "R7 data", res_data, d);
            chk(res_chan == c, "R7 channel order", res_chan, c);
            chk(res_pair == p, "R8 pair tag", res_pair, p);
            chk(cyc == cy, "R5 result timing", cyc, cy);
          end
        end
      end
    end
  end

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int c0, f, k;
    bit seen_low;
    repeat (3) @(negedge clk);
    chk(convst_n == 1'b1, "R1 convst", convst_n, 1);
    chk(cs_n == 1'b1, "R1 cs", cs_n, 1);
    chk(rd_n == 1'b1, "R1 rd", rd_n, 1);
    chk(res_valid == 1'b0, "R1 valid", res_valid, 0);
    chk(tmo == 1'b0, "R1 timeout", tmo, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // single start, pair 1
    preq = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0; preq = 1'b0;
    chk(pair_sel == 1'b1, "R4 select captured", pair_sel, 1);
    chk(convst_n == 1'b1, "R3 setup cycle", convst_n, 1);
    @(negedge clk);
    chk(convst_n == 1'b0, "R3 pulse starts", convst_n, 0);
    repeat (3) @(negedge clk);
    start = 1'b1; preq = 1'b0;
    @(negedge clk); start = 1'b0;
    c0 = conv_cnt;
    repeat (40) @(negedge clk);
    chk(conv_cnt == c0, "R3 start ignored while busy", conv_cnt, c0);

    // continuous run
    run = 1'b1;
    for (int i = 0; i < 5; i++) begin
      preq = i[0];
      f = falls_cnt;
      wait (falls_cnt != f);
      @(negedge clk);
      chk(convst_n == 1'b1 && pair_sel == preq, "R9 next setup", pair_sel, preq);
      @(negedge clk);
      chk(convst_n == 1'b0, "R9 next pulse", convst_n, 0);
    end
    run = 1'b0;
    repeat (60) @(negedge clk);
    chk(q_data.size() == 0, "R7 results drained", q_data.size(), 0);

    // timeout
    model_en = 1'b0;
    start = 1'b1;
    k = 0;
    for (int j = 1; j <= 200; j++) begin
      @(negedge clk);
      if (j == 1) start = 1'b0;
      if (tmo) begin k = j; break; end
    end
    chk(k == TO + 4, "R10 timeout cycle", k, TO + 4);
    @(negedge clk);
    chk(tmo == 1'b0, "R10 single pulse", tmo, 0);
    seen_low = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (!convst_n || !rd_n) seen_low = 1'b1;
    end
    chk(!seen_low, "R10 back to idle", seen_low, 0);
    model_en = 1'b1;

    // random traffic
    c0 = conv_cnt;
    repeat (3000) begin
      @(negedge clk);
      start = (($urandom % 8) == 0);
      if (($urandom % 64) == 0) run = ~run;
      preq = 1'($urandom % 2);
    end
    start = 1'b0; run = 1'b0;
    repeat (80) @(negedge clk);
    chk(q_data.size() == 0, "R7 random drained", q_data.size(), 0);
    chk(conv_cnt - c0 > 50, "R9 random progress", conv_cnt - c0, 51);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule